// File: doc/BRIEF.md
# Supply Supervisor with Window Watchdog

This block supervises the supply and the firmware of a microcontroller. It takes a digitised supply-good comparator level, a watchdog trigger line and two mode-select lines. It drives one active-low reset output. Short dips of the supply are filtered out. Once the supply is valid, reset is stretched for a fixed delay. After reset is released, the trigger line is ignored for a fixed window. A window watchdog then runs: a trigger that comes too early or too late pulls reset low again.

Every duration is counted in ticks of a timebase. The timebase is a prescaler of the system clock. The two mode lines stretch the tick period by 1, 2 or 4, or they switch the watchdog off entirely. All inputs are asynchronous and pass through two-flop synchronisers. The reset output is registered.

Top module: `wdg_supervisor`

## Requirements
- R1: `rst_out_n` is 0 while `rst_n` is asserted, and it stays 0 while `supply_ok` is low from power-on.
- R2: Once `supply_ok` is high, `rst_out_n` stays 0 for DLY_TICKS ticks, then goes to 1. The rise comes between (DLY_TICKS-1)·T and DLY_TICKS·T+8 clock cycles after the input edge, where T is the tick period.
- R3: A low pulse on `supply_ok` shorter than (FILT_TICKS-1)·T cycles leaves `rst_out_n` at 1.
- R4: A low level on `supply_ok` that lasts longer than FILT_TICKS·T+8 cycles drives `rst_out_n` to 0. Reset is then stretched again as in R2.
- R5: For IGN_TICKS ticks after `rst_out_n` rises, rising edges on `wd_trig` have no effect.
- R6: A trigger inside the open window keeps `rst_out_n` at 1. It starts a closed window of CLS_TICKS ticks, followed by an open window of OPN_TICKS ticks.
- R7: A trigger inside a closed window drives `rst_out_n` to 0 within 8 cycles. Reset is then stretched for DLY_TICKS ticks, and the ignore window starts again.
- R8: If no trigger arrives before the open window ends, `rst_out_n` goes to 0.
- R9: When {`mode_hi`,`mode_lo`} = 2'b11, the watchdog is off. Only supply faults drive `rst_out_n` low, and T = PRESCALE.
- R10: The mode code {`mode_hi`,`mode_lo`} sets the tick period T. Code 00 gives PRESCALE cycles, 01 gives 2·PRESCALE and 10 gives 4·PRESCALE.
- R11: Only a rising edge of `wd_trig` is a trigger. Holding the line high across a closed window does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Block power-on reset, active low, asynchronous |
| supply_ok | input | 1 | Supply-above-threshold comparator level (asynchronous) |
| wd_trig | input | 1 | Watchdog trigger line from firmware (asynchronous) |
| mode_lo | input | 1 | Mode select, low bit |
| mode_hi | input | 1 | Mode select, high bit |
| rst_out_n | output | 1 | Registered active-low reset to the microcontroller |

## Verification
Trigger offsets are drawn at random from two bands, measured from the previous trigger. One band lies inside the closed window and the other inside the open window. The band picked tells an early-trigger reset apart from a kept-alive run, and pulse widths vary so that edge detection is separated from level detection. Directed cases cover the rest:
- a trigger during the ignore window;
- a trigger line held high from a closed window into an open one;
- a silent open window, which must end in a timeout;
- supply dips just below and just above the filter length;
- each mode code, with the delay and timeout lengths measured to confirm the tick scaling and the watchdog-off mode.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        ST_HOLD   = 3'd0,
        ST_DELAY  = 3'd1,
        ST_IGNORE = 3'd2,
        ST_CLOSED = 3'd3,
        ST_OPEN   = 3'd4,
        ST_RUN    = 3'd5
    } sup_state_e;

    typedef enum logic [1:0] {
        MD_FAST = 2'b00,
        MD_MID  = 2'b01,
        MD_SLOW = 2'b10,
        MD_OFF  = 2'b11
    } wd_mode_e;

    // log2 of the tick stretch factor for a mode code
    function automatic logic [1:0] mode_shift(input logic [1:0] m);
        case (m)
            MD_MID:  return 2'd1;
            MD_SLOW: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic state_releases(input sup_state_e s);
        return (s == ST_IGNORE) || (s == ST_CLOSED) || (s == ST_OPEN) || (s == ST_RUN);
    endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] st_d, st_q;

        always_comb begin
            st_d = {st_q[0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= 2'b00;
            else        st_q <= st_d;
        end

        assign dout[i] = st_q[1];
    end
endmodule

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
    parameter int PRESCALE = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] shift,
    output logic       tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] BASE_TOP = PW'(PRESCALE - 1);

    typedef struct packed {
        logic [PW-1:0] base;
        logic [1:0]    scale;
        logic          tick;
    } tg_t;

    tg_t tg_d, tg_q;
    logic [1:0] scale_top;

    always_comb begin
        scale_top = 2'd0;
        case (shift)
            2'd1:    scale_top = 2'd1;
            2'd2:    scale_top = 2'd3;
            default: scale_top = 2'd0;
        endcase

        tg_d      = tg_q;
        tg_d.tick = 1'b0;
        if (tg_q.base >= BASE_TOP) begin
            tg_d.base = '0;
            if (tg_q.scale >= scale_top) begin
                tg_d.scale = 2'd0;
                tg_d.tick  = 1'b1;
            end else begin
                tg_d.scale = tg_q.scale + 2'd1;
            end
        end else begin
            tg_d.base = tg_q.base + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end

    assign tick = tg_q.tick;
endmodule

// File: rtl/wdg_supply_filter.sv
module wdg_supply_filter #(
    parameter int FILT_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic tick,
    output logic pwr_good
);
    localparam int FW = $clog2(FILT_TICKS + 1);
    localparam logic [FW-1:0] FILT_TOP = FW'(FILT_TICKS - 1);

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          good;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (sup_ok) begin
            // supply recovery is accepted at once
            flt_d.cnt  = '0;
            flt_d.good = 1'b1;
        end else if (flt_q.good) begin
            if (tick) begin
                if (flt_q.cnt >= FILT_TOP) begin
                    flt_d.cnt  = '0;
                    flt_d.good = 1'b0;
                end else begin
                    flt_d.cnt = flt_q.cnt + 1'b1;
                end
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign pwr_good = flt_q.good;
endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
#(
    parameter int DLY_TICKS = 16,
    parameter int IGN_TICKS = 32,
    parameter int CLS_TICKS = 16,
    parameter int OPN_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       tick,
    input  logic       kick,
    input  logic       wd_off,
    output sup_state_e state,
    output logic       rst_out_n
);
    localparam int MAXT = (DLY_TICKS > IGN_TICKS ? DLY_TICKS : IGN_TICKS) >
                          (CLS_TICKS > OPN_TICKS ? CLS_TICKS : OPN_TICKS) ?
                          (DLY_TICKS > IGN_TICKS ? DLY_TICKS : IGN_TICKS) :
                          (CLS_TICKS > OPN_TICKS ? CLS_TICKS : OPN_TICKS);
    localparam int CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] DLY_TOP = CW'(DLY_TICKS - 1);
    localparam logic [CW-1:0] IGN_TOP = CW'(IGN_TICKS - 1);
    localparam logic [CW-1:0] CLS_TOP = CW'(CLS_TICKS - 1);
    localparam logic [CW-1:0] OPN_TOP = CW'(OPN_TICKS - 1);

    typedef struct packed {
        sup_state_e    st;
        logic [CW-1:0] cnt;
        logic          out_n;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!pwr_good) begin
            f_d.st  = ST_HOLD;
            f_d.cnt = '0;
        end else begin
            case (f_q.st)
                ST_HOLD: begin
                    f_d.st  = ST_DELAY;
                    f_d.cnt = '0;
                end
                ST_DELAY: begin
                    if (tick) begin
                        if (f_q.cnt >= DLY_TOP) begin
                            f_d.st  = ST_IGNORE;
                            f_d.cnt = '0;
                        end else begin
                            f_d.cnt = f_q.cnt + 1'b1;
                        end
                    end
                end
                ST_IGNORE: begin
                    if (tick) begin
                        if (f_q.cnt >= IGN_TOP) begin
                            f_d.st  = wd_off ? ST_RUN : ST_OPEN;
                            f_d.cnt = '0;
                        end else begin
                            f_d.cnt = f_q.cnt + 1'b1;
                        end
                    end
                end
                ST_OPEN: begin
                    if (wd_off) begin
                        f_d.st  = ST_RUN;
                        f_d.cnt = '0;
                    end else if (kick) begin
                        f_d.st  = ST_CLOSED;
                        f_d.cnt = '0;
                    end else if (tick) begin
                        if (f_q.cnt >= OPN_TOP) begin
                            f_d.st  = ST_DELAY;
                            f_d.cnt = '0;
                        end else begin
                            f_d.cnt = f_q.cnt + 1'b1;
                        end
                    end
                end
                ST_CLOSED: begin
                    if (wd_off) begin
                        f_d.st  = ST_RUN;
                        f_d.cnt = '0;
                    end else if (kick) begin
                        f_d.st  = ST_DELAY;
                        f_d.cnt = '0;
                    end else if (tick) begin
                        if (f_q.cnt >= CLS_TOP) begin
                            f_d.st  = ST_OPEN;
                            f_d.cnt = '0;
                        end else begin
                            f_d.cnt = f_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (!wd_off) begin
                        f_d.st  = ST_IGNORE;
                        f_d.cnt = '0;
                    end
                end
                default: begin
                    f_d.st  = ST_HOLD;
                    f_d.cnt = '0;
                end
            endcase
        end
        f_d.out_n = state_releases(f_d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st    <= ST_HOLD;
            f_q.cnt   <= '0;
            f_q.out_n <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign state     = f_q.st;
    assign rst_out_n = f_q.out_n;
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
#(
    parameter int PRESCALE   = 1000,
    parameter int FILT_TICKS = 4,
    parameter int DLY_TICKS  = 16,
    parameter int IGN_TICKS  = 32,
    parameter int CLS_TICKS  = 16,
    parameter int OPN_TICKS  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wd_trig,
    input  logic mode_lo,
    input  logic mode_hi,
    output logic rst_out_n
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_in, syn_out;
    logic             sup_s, trig_s;
    logic [1:0]       mode_s;
    logic             tick, pwr_good, kick, wd_off;
    sup_state_e       fsm_state;

    typedef struct packed {
        logic trig_prev;
    } edg_t;

    edg_t edg_d, edg_q;

    assign raw_in = {mode_hi, mode_lo, wd_trig, supply_ok};

    wdg_sync #(.W(NSYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn_out)
    );

    assign sup_s  = syn_out[0];
    assign trig_s = syn_out[1];
    assign mode_s = syn_out[3:2];
    assign wd_off = (mode_s == MD_OFF);

    always_comb begin
        edg_d.trig_prev = trig_s;
        kick            = trig_s & ~edg_q.trig_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edg_q <= '0;
        else        edg_q <= edg_d;
    end

    wdg_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .shift(mode_shift(mode_s)),
        .tick (tick)
    );

    wdg_supply_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .sup_ok  (sup_s),
        .tick    (tick),
        .pwr_good(pwr_good)
    );

    wdg_fsm #(
        .DLY_TICKS(DLY_TICKS),
        .IGN_TICKS(IGN_TICKS),
        .CLS_TICKS(CLS_TICKS),
        .OPN_TICKS(OPN_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .tick     (tick),
        .kick     (kick),
        .wd_off   (wd_off),
        .state    (fsm_state),
        .rst_out_n(rst_out_n)
    );
endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk
    import wdg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_good,
    input logic       sup_s,
    input logic       tick,
    input logic       kick,
    input logic       wd_off,
    input sup_state_e state,
    input logic       rst_out_n
);
    always_comb begin
        if (!rst_n) AST_RESET_LOW: assert (!rst_out_n); // R1
    end

    AST_BAD_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !rst_out_n); // R1

    AST_RELEASE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(state) == ST_DELAY); // R2

    AST_FAULT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_good) |-> $past(!sup_s)); // R4

    AST_IGNORE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && pwr_good) |=> rst_out_n); // R5

    AST_EARLY_KICK_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSED && kick && pwr_good && !wd_off) |=> !rst_out_n); // R7

    AST_OFF_MODE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_off && pwr_good && rst_out_n) |=> rst_out_n); // R9

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R10
endmodule

bind wdg_supervisor wdg_supervisor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .sup_s    (sup_s),
    .tick     (tick),
    .kick     (kick),
    .wd_off   (wd_off),
    .state    (fsm_state),
    .rst_out_n(rst_out_n)
);

// File: tb/wdg_supervisor_test.sv
module wdg_supervisor_test;
    localparam int PRE  = 4;
    localparam int FILT = 4;
    localparam int DLY  = 8;
    localparam int IGN  = 16;
    localparam int CLS  = 8;
    localparam int OPN  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic wd_trig = 1'b0;
    logic mode_lo = 1'b0;
    logic mode_hi = 1'b0;
    logic rst_out_n;

    int n_chk = 0;
    int n_bad = 0;
    int lows = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wdg_supervisor #(
        .PRESCALE(PRE), .FILT_TICKS(FILT), .DLY_TICKS(DLY),
        .IGN_TICKS(IGN), .CLS_TICKS(CLS), .OPN_TICKS(OPN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_trig(wd_trig),
        .mode_lo(mode_lo), .mode_hi(mode_hi), .rst_out_n(rst_out_n)
    );

    // tick period in clocks for a mode code (R10)
    function automatic int per_of(input int code);
        case (code)
            1:       return PRE * 2;
            2:       return PRE * 4;
            default: return PRE;
        endcase
    endfunction

    // 0 = early (closed), 1 = valid (open), 2 = too close to a boundary
    function automatic int kick_class(input int off);
        if (off >= 12 && off <= (CLS - 1) * PRE - 4) return 0;
        if (off >= CLS * PRE + 4 && off <= (CLS + OPN - 1) * PRE - 4) return 1;
        return 2;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst_out_n) lows++;
        end
    endtask

    task automatic time_to(input logic lvl, input int limit, output int cyc);
        cyc = 0;
        while (rst_out_n !== lvl && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic set_mode(input int code);
        mode_lo = code[0];
        mode_hi = code[1];
        gap(4);
    endtask

    task automatic dip_and_check(input int code, input string req);
        int c;
        int p;
        p = per_of(code);
        supply_ok = 1'b0;
        time_to(1'b0, FILT * p + 8, c);
        chk(rst_out_n == 1'b0, req, c, FILT * p);
        gap(6);
        supply_ok = 1'b1;
        time_to(1'b1, DLY * p + 40, c);
        chk(c >= (DLY - 1) * p && c <= DLY * p + 8, req, c, DLY * p);
    endtask

    initial begin
        int c;
        int off;
        int w;
        int cls;
        // R1: reset state
        gap(3);
        chk(rst_out_n == 1'b0, "R1 in reset", rst_out_n, 0);
        rst_n = 1'b1;
        gap(100);
        chk(rst_out_n == 1'b0, "R1 supply low", rst_out_n, 0);

        // R2: power-up delay, mode 00
        supply_ok = 1'b1;
        time_to(1'b1, 200, c);
        chk(c >= (DLY - 1) * PRE && c <= DLY * PRE + 8, "R2 delay", c, DLY * PRE);

        // R5: trigger inside ignore window, then first trigger in open window (R6)
        lows = 0;
        gap(IGN * PRE / 2);
        wd_trig = 1'b1; gap(3); wd_trig = 1'b0;
        gap(IGN * PRE / 2 - 3 + OPN * PRE / 2);
        chk(lows == 0, "R5 ignore window", lows, 0);

        // random trigger offsets
        for (int it = 0; it < 30; it++) begin
            off = 0;
            cls = 2;
            while (cls == 2) begin
                off = 12 + int'($urandom % 80);
                cls = kick_class(off);
            end
            w = 2 + int'($urandom % 6);
            lows = 0;
            wd_trig = 1'b1; gap(w); wd_trig = 1'b0;
            gap(off - w);
            chk(lows == 0, "R6 valid trigger keeps reset high", lows, 0);
            if (cls == 0) begin
                wd_trig = 1'b1;
                time_to(1'b0, 8, c);
                chk(rst_out_n == 1'b0, "R7 early trigger", c, 4);
                gap(2);
                wd_trig = 1'b0;
                time_to(1'b1, DLY * PRE + 40, c);
                chk(c >= (DLY - 2) * PRE && c <= DLY * PRE + 8, "R7 restretch", c, DLY * PRE);
                lows = 0;
                gap(IGN * PRE / 2);
                if ($urandom % 2 == 1) begin
                    wd_trig = 1'b1; gap(w); wd_trig = 1'b0;
                end else gap(w);
                gap(IGN * PRE / 2 - w + OPN * PRE / 2);
                chk(lows == 0, "R5 ignore after early reset", lows, 0);
            end
        end

        // R11: hold trigger high from closed into open window, then new edge
        lows = 0;
        wd_trig = 1'b1;
        gap((CLS + 2) * PRE);
        wd_trig = 1'b0;
        gap(8);
        chk(lows == 0, "R11 level is no trigger", lows, 0);
        wd_trig = 1'b1; gap(3); wd_trig = 1'b0;
        // R8: no more triggers -> timeout
        time_to(1'b0, 200, c);
        c = c + 3;
        chk(c >= (CLS + OPN - 1) * PRE && c <= (CLS + OPN) * PRE + 8, "R8 missed trigger", c, (CLS + OPN) * PRE);
        time_to(1'b1, DLY * PRE + 40, c);
        chk(rst_out_n == 1'b1, "R8 recovers", rst_out_n, 1);

        // R9: watchdog off
        set_mode(3);
        lows = 0;
        gap(2000);
        chk(lows == 0, "R9 watchdog off", lows, 0);
        // R3: short dip filtered
        lows = 0;
        supply_ok = 1'b0; gap((FILT - 1) * PRE - 4); supply_ok = 1'b1;
        gap(50);
        chk(lows == 0, "R3 short dip ignored", lows, 0);
        // R4: long dip
        dip_and_check(3, "R4 long dip");

        // R10: tick scaling, modes 01 and 10
        set_mode(1);
        dip_and_check(1, "R10 mode 01");
        set_mode(2);
        dip_and_check(2, "R10 mode 10");
        time_to(1'b0, (IGN + OPN) * per_of(2) + 40, c);
        chk(c >= (IGN + OPN - 1) * per_of(2) && c <= (IGN + OPN) * per_of(2) + 8,
            "R10 mode 10 timeout", c, (IGN + OPN) * per_of(2));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule